// File: doc/BRIEF.md
# Fractional PLL Rate Calculator

This block works out the output frequency of a fractional-N PLL from the frequency of its reference clock and the values of its divider fields. The output rate is the reference rate multiplied by an integer factor, plus a fractional part equal to the reference rate times a numerator divided by a denominator. That sum can then be divided by an optional output divider.

A caller loads every operand and pulses `start`. The block captures the operands and runs a serial restoring divider that produces one quotient bit per cycle. The same divider is used twice: first for the fractional term, then for the output divider. When the calculation finishes, the block raises `done` for one cycle and holds `rate` until the next accepted start. All divisions truncate.

Top module: `pll_rate_calc`

## Requirements
- R1: Only the low 10 bits of `mult_int` are used as the integer factor. The upper bits have no effect on `rate`.
- R2: Only the low 19 bits of `frac_num` and of `frac_den` are used. The upper bits have no effect on `rate`.
- R3: If the masked denominator is non-zero, `rate` includes the term floor(`ref_rate` × numerator / denominator), added to `ref_rate` × integer factor.
- R4: If the masked denominator is zero, the fractional term is left out, and `rate` equals `ref_rate` × integer factor (before any output division).
- R5: If `odiv_en` is 1, the sum is divided by `odiv` + 1 and the quotient is truncated.
- R6: If `odiv_en` is 0, `odiv` has no effect and the sum is not divided.
- R7: The product of the reference rate and the numerator is formed at full 64-bit width, so no bits are lost when the product is larger than 32 bits.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. No second `done` pulse follows from it, and the result belongs to the first request.
- R9: `done` stays high for exactly one cycle, `busy` is 0 in that cycle, and `rate` changes only in a cycle where `done` is 1.
- R10: After reset, `busy`, `done` and `rate` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures the operands and begins a calculation when idle |
| ref_rate | input | 32 | Reference clock rate |
| mult_int | input | 32 | Integer multiplier word; only the low 10 bits are used |
| frac_num | input | 32 | Fractional numerator word; only the low 19 bits are used |
| frac_den | input | 32 | Fractional denominator word; only the low 19 bits are used |
| odiv | input | 4 | Output divider field; the divisor is this value plus one |
| odiv_en | input | 1 | An output divider is present |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle pulse when `rate` is updated |
| rate | output | 64 | Computed rate, held until the next completion |

## Verification
The bench sets stray upper bits in the multiplier and fraction words. A design that failed to mask them would return a very different rate. Two further cases check the fractional term. A denominator of zero must drop the term entirely; a design that divided anyway would return an all-ones quotient. A denominator whose low 19 bits are zero but whose upper bits are set must also drop the term. One case has a numerator product above 32 bits, which a narrow multiplier would truncate. Other cases cover the output divider: the maximum divider value, a divider of zero (divide by one), and a disabled divider carrying a non-zero field, where a design that ignored the enable would scale the result. A `start` pulse issued during a calculation must not cause a second completion or change the returned value.

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int PW  = 32,
  parameter int LW  = 10,
  parameter int MNW = 19,
  parameter int PDW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PW-1:0]   ref_rate,
  input  logic [31:0]     mult_int,
  input  logic [31:0]     frac_num,
  input  logic [31:0]     frac_den,
  input  logic [PDW-1:0]  odiv,
  input  logic            odiv_en,
  output logic            busy,
  output logic            done,
  output logic [63:0]     rate
);
  localparam int DW = 64;
  localparam int CW = $clog2(DW);
  localparam logic [31:0] LMASK = 32'((64'd1 << LW) - 64'd1);
  localparam logic [31:0] MNMASK = 32'((64'd1 << MNW) - 64'd1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_FRAC, S_SUM, S_POST} st_t;
  st_t st;

  logic [PW-1:0]  ref_q;
  logic [31:0]    l_q, m_q, n_q;
  logic [PDW-1:0] pd_q;
  logic           pen_q;
  logic [DW-1:0]  acc_q;

  logic [DW-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0]  cnt_q;
  logic [DW:0]    rem_sh, rem_sub;
  logic           ge;
  logic [DW-1:0]  rem_nx, quo_nx;
  logic [DW-1:0]  base, prod_m;
  logic           last;

  assign base    = DW'(ref_q) * DW'(l_q);
  assign prod_m  = DW'(ref_q) * DW'(m_q);
  assign rem_sh  = {rem_q, quo_q[DW-1]};
  assign rem_sub = rem_sh - {1'b0, dvs_q};
  assign ge      = rem_sh >= {1'b0, dvs_q};
  assign rem_nx  = ge ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
  assign quo_nx  = {quo_q[DW-2:0], ge};
  assign last    = cnt_q == CW'(DW-1);
  assign busy    = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      done  <= 1'b0;
      rate  <= '0;
      ref_q <= '0;
      l_q   <= '0;
      m_q   <= '0;
      n_q   <= '0;
      pd_q  <= '0;
      pen_q <= 1'b0;
      acc_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ref_q <= ref_rate;
          l_q   <= mult_int & LMASK;
          m_q   <= frac_num & MNMASK;
          n_q   <= frac_den & MNMASK;
          pd_q  <= odiv;
          pen_q <= odiv_en;
          st    <= S_SETUP;
        end
        S_SETUP: begin
          cnt_q <= '0;
          rem_q <= '0;
          if (n_q != 0) begin
            quo_q <= prod_m;
            dvs_q <= DW'(n_q);
            st    <= S_FRAC;
          end else begin
            acc_q <= base;
            st    <= S_SUM;
          end
        end
        S_FRAC: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            acc_q <= base + quo_nx;
            st    <= S_SUM;
          end
        end
        S_SUM: begin
          cnt_q <= '0;
          rem_q <= '0;
          if (pen_q) begin
            quo_q <= acc_q;
            dvs_q <= DW'(pd_q) + DW'(1);
            st    <= S_POST;
          end else begin
            rate <= acc_q;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_POST: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            rate <= quo_nx;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [63:0] rate
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_rate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate) |-> done);
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind pll_rate_calc pll_rate_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .rate(rate)
);

// File: tb/pll_rate_calc_bench.sv
module pll_rate_calc_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] ref_rate = 0, mult_int = 0, frac_num = 0, frac_den = 0;
  logic [3:0]  odiv = 0;
  logic        odiv_en = 0;
  logic        busy, done;
  logic [63:0] rate;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_rate_calc u_pll_rate_calc (.*);

  function automatic logic [63:0] model(input logic [31:0] p, l, m, n,
                                        input logic [3:0] pd, input logic pe);
    logic [63:0] r, lm, mm, nm;
    lm = {32'd0, l & 32'h3ff};
    mm = {32'd0, m & 32'h7ffff};
    nm = {32'd0, n & 32'h7ffff};
    r = {32'd0, p} * lm;
    if (nm != 0) r = r + ({32'd0, p} * mm) / nm;
    if (pe) r = r / ({60'd0, pd} + 64'd1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic kick(input logic [31:0] p, l, m, n, input logic [3:0] pd, input logic pe);
    @(negedge clk);
    ref_rate = p; mult_int = l; frac_num = m; frac_den = n; odiv = pd; odiv_en = pe;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input string req, input logic [31:0] p, l, m, n,
                     input logic [3:0] pd, input logic pe);
    logic [63:0] e, held;
    bit got;
    e = model(p, l, m, n, pd, pe);
    kick(p, l, m, n, pd, pe);
    wait_done(got);
    check(got, req, 64'(got), 64'd1);
    check(rate == e, req, rate, e);
    held = rate;
    @(negedge clk);
    check(!done && rate == held, {req, " R9 hold"}, rate, held);
  endtask

  task automatic t_reset();
    check(!busy, "R10 busy", 64'(busy), 0);
    check(!done, "R10 done", 64'(done), 0);
    check(rate == 0, "R10 rate", rate, 0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] e;
    bit got;
    e = model(32'd19_200_000, 32'd50, 32'd3, 32'd8, 4'd0, 1'b0);
    kick(32'd19_200_000, 32'd50, 32'd3, 32'd8, 4'd0, 1'b0);
    repeat (5) @(negedge clk);
    kick(32'd1000, 32'd1, 32'd0, 32'd0, 4'd0, 1'b0);
    wait_done(got);
    check(rate == e, "R8 first result kept", rate, e);
    @(negedge clk);
    got = 0;
    for (int i = 0; i < 300; i++) begin
      if (done || busy) got = 1;
      @(negedge clk);
    end
    check(!got, "R8 no second run", 64'(got), 0);
    check(rate == e, "R8 rate unchanged", rate, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    run("R3 fractional", 32'd19_200_000, 32'd40, 32'd1, 32'd3, 4'd0, 1'b0);
    run("R4 den zero", 32'd27_000_000, 32'd36, 32'd5, 32'd0, 4'd0, 1'b0);
    run("R2 den masked to zero", 32'd27_000_000, 32'd36, 32'd5, 32'h0008_0000, 4'd0, 1'b0);
    run("R1 L upper bits", 32'd24_000_000, 32'hFFFF_F42A, 32'd0, 32'd0, 4'd0, 1'b0);
    run("R2 M/N upper bits", 32'd19_200_000, 32'd10, 32'hABC8_0007, 32'h1230_000D, 4'd0, 1'b0);
    run("R7 wide product", 32'hFFFF_FFF1, 32'd1023, 32'h7FFFF, 32'd3, 4'd0, 1'b0);
    run("R5 post div", 32'd19_200_000, 32'd52, 32'd7, 32'd11, 4'd2, 1'b1);
    run("R5 post div max", 32'd100_000_007, 32'd17, 32'd1, 32'd2, 4'd15, 1'b1);
    run("R5 post div one", 32'd33_333_333, 32'd3, 32'd2, 32'd7, 4'd0, 1'b1);
    run("R6 div disabled", 32'd33_333_333, 32'd3, 32'd2, 32'd7, 4'd9, 1'b0);
    t_busy_ignore();
    finished = 1;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    finished = 1;
  end

  initial begin
    wait (finished);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule